// File: doc/BRIEF.md
# Sensor Dwell-Time Trigger Latch

This block decides when a presence has lasted long enough to act on. It watches a small group of active-high presence sensors and a slow oscillator. Whenever no sensor is active, a small occupancy counter is held at zero. While at least one sensor stays active, the counter steps forward once on every falling edge of the oscillator. When the counter reaches its all-ones value it raises a qualifier, `valid_o`. Reaching that value means the presence has lasted for three oscillator periods with the default two-bit counter.

The qualifier lasts only while the counter sits at its terminal value, because the counter keeps only its low bits and wraps to zero on the next tick. For this reason a sticky latch captures the qualifier and holds the actuator output `trigger_o` until an operator applies an active-low manual clear. The oscillator, the sensors and the clear are asynchronous to the system clock. Each passes through a two-stage synchroniser before use, and a falling edge of the synchronised oscillator becomes a one-cycle advance enable. The oscillator rate is chosen so that three periods span the required dwell, about 1.5 s.

Top module: `dwell_trigger`

## Requirements
- R1: While no synchronised sensor is active, the count is 0 from the cycle after the sensors go idle onward. Inputs reach the logic two system clock cycles after they change.
- R2: While any sensor is active, the count increases by one, modulo 2^CNT_W, once per falling edge of the oscillator, and is otherwise unchanged. Bit 0 toggles on every tick, and bit 1 takes bit 1 XOR bit 0.
- R3: `valid_o` is 1 exactly when every count bit is 1 (count 3 for CNT_W=2).
- R4: A tick at count 3 wraps the count to 0, which drops `valid_o`.
- R5: `trigger_o` becomes 1 in the cycle after `valid_o` is seen with the clear idle. It then stays 1 while the clear is idle (1).
- R6: While the synchronised `clr_n_i` is 0, `trigger_o` goes to 0 and stays 0, even when `valid_o` is 1 at the same time (the clear has priority).
- R7: If the sensors go idle before the count reaches 3, the count returns to 0 and `trigger_o` keeps its value.
- R8: After reset, the count is 0, `valid_o` is 0 and `trigger_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| osc_i | input | 1 | Slow oscillator; its falling edges are ticks |
| sense_i | input | N_SENSE | Active-high presence sensors |
| clr_n_i | input | 1 | Active-low manual clear of the trigger, idle 1 |
| count_o | output | CNT_W | Current occupancy count |
| valid_o | output | 1 | Count is at its terminal (all-ones) value |
| trigger_o | output | 1 | Latched actuator drive |

## Verification
The assertions assume that each oscillator level lasts at least two system clock cycles. Under that assumption every falling edge produces exactly one isolated advance pulse, and a sensor or clear level lasts long enough to pass the synchroniser. The random stimulus draws oscillator half-periods of two to six cycles and holds sensor and clear values for several cycles. The directed cases hold every level for at least four cycles. A bench reference model, written from the requirements, delays each input by the synchroniser latency and uses modular arithmetic to predict the count and the latch.

// File: rtl/dwell_pkg.sv
package dwell_pkg;

  typedef enum logic [1:0] {
    LATCH_HOLD  = 2'd0,
    LATCH_SET   = 2'd1,
    LATCH_CLEAR = 2'd2
  } latch_act_e;

  // Ripple incrementer: bit i flips when every lower bit is 1.
  function automatic logic [31:0] ripple_next(input logic [31:0] cur, input int w);
    logic [31:0] nxt;
    logic        carry;
    nxt   = cur;
    carry = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i < w) begin
        nxt[i] = cur[i] ^ carry;
        carry  = carry & cur[i];
      end
    end
    return nxt;
  endfunction

  // Terminal detect: AND of the low w bits.
  function automatic logic all_ones(input logic [31:0] cur, input int w);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i < w) r = r & cur[i];
    end
    return r;
  endfunction

  // Latch decision: the clear has priority over the set.
  function automatic latch_act_e latch_decide(input logic clr_n, input logic set);
    if (!clr_n) return LATCH_CLEAR;
    if (set)    return LATCH_SET;
    return LATCH_HOLD;
  endfunction

endpackage

// File: rtl/dwell_sync.sv
module dwell_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dwell_fall_det.sv
module dwell_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;

  // A falling edge yields a single-cycle pulse.
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R2
endmodule

// File: rtl/dwell_counter.sv
module dwell_counter
  import dwell_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             term_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = CNT_W'(ripple_next(32'(cnt_q), CNT_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (adv_i)     cnt_q <= cnt_inc;
  end

  assign cnt_o  = cnt_q;
  assign term_o = all_ones(32'(cnt_q), CNT_W);

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (cnt_o == '0)); // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !adv_i) |=> $stable(cnt_o)); // R2
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && adv_i && term_o) |=> (cnt_o == '0)); // R4
endmodule

// File: rtl/dwell_latch.sv
module dwell_latch
  import dwell_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_n_i,
  output logic q_o
);
  latch_act_e act;
  logic       q_q;

  assign act = latch_decide(clr_n_i, set_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else begin
      case (act)
        LATCH_CLEAR: q_q <= 1'b0;
        LATCH_SET:   q_q <= 1'b1;
        default:     q_q <= q_q;
      endcase
    end
  end

  assign q_o = q_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_i |=> !q_o); // R6
  AST_SET_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_n_i) |=> q_o); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && clr_n_i) |=> q_o); // R5
endmodule

// File: rtl/dwell_trigger.sv
module dwell_trigger
  import dwell_pkg::*;
#(
  parameter int CNT_W       = 2,
  parameter int N_SENSE     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_i,
  input  logic [N_SENSE-1:0] sense_i,
  input  logic               clr_n_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               valid_o,
  output logic               trigger_o
);
  localparam int SYNC_W = N_SENSE + 2;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b0, {N_SENSE{1'b0}}};

  logic [SYNC_W-1:0]  raw_w;
  logic [SYNC_W-1:0]  syn_w;
  logic [N_SENSE-1:0] sense_s;
  logic               osc_s;
  logic               clr_n_s;
  logic               any_active;
  logic               adv_tick;
  logic               term_w;

  assign raw_w = {clr_n_i, osc_i, sense_i};

  dwell_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_w), .q_o(syn_w)
  );

  assign sense_s    = syn_w[N_SENSE-1:0];
  assign osc_s      = syn_w[N_SENSE];
  assign clr_n_s    = syn_w[N_SENSE+1];
  assign any_active = |sense_s;

  dwell_fall_det u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(osc_s), .fall_o(adv_tick)
  );

  dwell_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .active_i(any_active), .adv_i(adv_tick),
    .cnt_o(count_o), .term_o(term_w)
  );

  dwell_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(term_w), .clr_n_i(clr_n_s), .q_o(trigger_o)
  );

  assign valid_o = term_w;

  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(adv_tick)); // R3
  AST_IDLE_KEEPS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_active && !valid_o && clr_n_s) |=> $stable(trigger_o)); // R7
endmodule

// File: tb/dwell_trigger_test.sv
module dwell_trigger_test;
  localparam int CNT_W = 2;
  localparam int NS    = 2;
  localparam int HALF  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          osc = 1'b1;
  logic [NS-1:0] sense = '0;
  logic          clr_n = 1'b1;
  logic [CNT_W-1:0] count_o;
  logic          valid_o, trigger_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0, cmp_on = 0;

  always #2 clk = ~clk;

  dwell_trigger #(.CNT_W(CNT_W), .N_SENSE(NS)) uut (
    .clk(clk), .rst_n(rst_n), .osc_i(osc), .sense_i(sense), .clr_n_i(clr_n),
    .count_o(count_o), .valid_o(valid_o), .trigger_o(trigger_o)
  );

  // Reference model from the requirements: two-cycle input latency,
  // modular count, set-on-terminal latch with clear priority.
  logic [NS-1:0] sa1, sa2;
  logic o1, o2, o3, c1, c2;
  int   m_cnt;
  logic m_trig;

  function automatic int model_next(int c);
    return (c + 1) % (1 << CNT_W);
  endfunction
  function automatic bit model_term(int c);
    return c == (1 << CNT_W) - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa1 <= '0; sa2 <= '0; o1 <= 0; o2 <= 0; o3 <= 0; c1 <= 1; c2 <= 1;
      m_cnt <= 0; m_trig <= 0;
    end else begin
      sa1 <= sense; sa2 <= sa1;
      o1 <= osc; o2 <= o1; o3 <= o2;
      c1 <= clr_n; c2 <= c1;
      if (sa2 == '0)        m_cnt <= 0;
      else if (o3 && !o2)   m_cnt <= model_next(m_cnt);
      if (!c2)                    m_trig <= 0;
      else if (model_term(m_cnt)) m_trig <= 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse();
    osc = 1'b0; wait_cyc(HALF);
    osc = 1'b1; wait_cyc(HALF);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R8 count", count_o, 0);
    chk("R8 valid", valid_o, 0);
    chk("R8 trigger", trigger_o, 0);

    sense = 2'b01; wait_cyc(HALF);
    chk("R2 no tick no advance", count_o, 0);
    pulse();
    chk("R2 first tick", count_o, 1);
    pulse();
    chk("R2 second tick", count_o, 2);
    chk("R3 valid low at 2", valid_o, 0);
    sense = 2'b00; wait_cyc(HALF);
    chk("R7 idle clears count", count_o, 0);
    chk("R7 latch untouched", trigger_o, 0);
    chk("R1 held at zero", count_o, 0);

    sense = 2'b10;
    pulse(); pulse(); pulse();
    chk("R2 third tick", count_o, 3);
    chk("R3 valid at 3", valid_o, 1);
    chk("R5 trigger set", trigger_o, 1);
    pulse();
    chk("R4 wrap to 0", count_o, 0);
    chk("R4 valid dropped", valid_o, 0);
    chk("R5 trigger sticky", trigger_o, 1);

    clr_n = 1'b0; wait_cyc(HALF);
    chk("R6 clear", trigger_o, 0);
    pulse(); pulse(); pulse();
    chk("R3 valid under clear", valid_o, 1);
    chk("R6 clear wins over valid", trigger_o, 0);
    clr_n = 1'b1; wait_cyc(HALF);
    chk("R5 set after clear release", trigger_o, 1);
    sense = 2'b00; wait_cyc(HALF);
    chk("R1 idle count", count_o, 0);
    chk("R7 trigger kept on idle", trigger_o, 1);

    // Random phase against the model.
    void'($urandom(32'd20240917));
    cmp_on = 1;
    fork
      begin
        for (int k = 0; k < 600; k++) begin
          osc = ~osc;
          wait_cyc($urandom_range(6, 2));
        end
      end
      begin
        for (int k = 0; k < 150; k++) begin
          sense = ($urandom_range(3, 0) == 0) ? 2'b00 : NS'($urandom_range(3, 1));
          clr_n = ($urandom_range(9, 0) != 0);
          wait_cyc($urandom_range(40, 3));
        end
      end
      begin
        while (cmp_on) begin
          @(negedge clk);
          chk(sa2 == '0 ? "R1 model count" : "R2 model count", count_o, m_cnt);
          chk("R3 model valid", valid_o, model_term(m_cnt));
          chk(c2 ? "R5 model trigger" : "R6 model trigger", trigger_o, m_trig);
          if (n_chk > 12000) cmp_on = 0;
        end
      end
    join_any
    cmp_on = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule